// File: doc/BRIEF.md
# Hiccup Over-Current Retry Controller

This block is the digital side of over-current protection for a synchronous buck converter. An external comparator watches the voltage across the low-side switch while that switch conducts. The comparator reports 1 when the load current is above the limit. Ringing right after the low-side switch turns on can make the comparator fire falsely, so the block only looks at it after a programmable number of system-clock cycles of continuous low-side conduction.

A qualified trip latches a fault and enters a hiccup hold. During the hold the block forces the soft-start node to ground and counts switching-cycle ticks. After a fixed number of ticks the fault clears and soft-start is released, which starts a new ramp. If the overload is still there, the next qualified sample trips again, so the converter keeps retrying until the overload goes away.

Detection stays armed during soft-start. Dropping power-on-ready abandons any hold at once and keeps the soft-start node discharged.

Top module: `hiccup_ocp_ctrl`

## Requirements
- R1: While reset is asserted, and after it until power-on-ready is seen high, `ss_discharge` is 1 and both `oc_fault` and `hiccup_busy` are 0.
- R2: A clock edge with `por_ok` low sets `oc_fault` and `hiccup_busy` to 0. `ss_discharge` is 1 whenever `por_ok` is low.
- R3: The first clock edge with `por_ok` high after an off period enters normal running: `ss_discharge`, `oc_fault` and `hiccup_busy` are all 0 after that edge.
- R4: `oc_cmp` is ignored at every edge where `ls_on` is 0.
- R5: `oc_cmp` is ignored at the first BLANK_CYC consecutive edges at which `ls_on` is 1. Any edge with `ls_on` at 0 restarts this blanking count.
- R6: While running, `oc_cmp` = 1 at an edge past the blanking window (the (BLANK_CYC+1)-th or later consecutive edge with `ls_on` = 1) sets `oc_fault`, `hiccup_busy` and `ss_discharge` to 1 from that edge.
- R7: The hold advances only at edges where `sw_tick` = 1. It stays in force through 4095 ticks. At the edge carrying the 4096th tick, `oc_fault`, `hiccup_busy` and `ss_discharge` all return to 0.
- R8: During the hold, `oc_cmp` is ignored and does not restart or lengthen the hold.
- R9: When the overload is still present after release, the block trips again once the blanking window has passed, and starts a fresh hold.
- R10: When `por_ok` drops during a hold, the tick count is discarded. After `por_ok` returns the block runs normally, and a later trip again needs a full 4096 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_ok | input | 1 | Power-on-ready; low forces the off state |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| ls_on | input | 1 | Low-side gate drive is on |
| oc_cmp | input | 1 | Over-current comparator, 1 = limit exceeded |
| ss_discharge | output | 1 | Command to ground the soft-start node |
| oc_fault | output | 1 | Latched over-current fault |
| hiccup_busy | output | 1 | Hiccup hold in progress |

## Verification
The bench shortens the blanking window to 6 clocks so the last blanked edge and the first sampled edge are easy to place exactly. The hold keeps its default length of 4096 ticks, so the release edge is checked at the real terminal count: the bench checks the state after tick 4095 and again after tick 4096. With these values the bench can also check a full retry, an abort of the hold by power-on-ready midway, and a second full hold after that abort.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ocp_state_t;
endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ocp_blank_window.sv
module ocp_blank_window #(
  parameter int BLANK_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ls_on,
  output logic sample_en
);
  generate
    if (BLANK_CYC == 0) begin : g_noblank
      assign sample_en = ls_on;
    end else begin : g_blank
      localparam int BW = $clog2(BLANK_CYC + 1);
      localparam logic [BW-1:0] LIMIT = BW'(BLANK_CYC);
      logic [BW-1:0] cnt_q, cnt_d;
      logic          cnt_full;

      assign cnt_full = (cnt_q == LIMIT);

      always_comb begin
        cnt_d = cnt_q;
        if (!ls_on)         cnt_d = '0;
        else if (!cnt_full) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign sample_en = ls_on & cnt_full;

      // R5: no sample on the first edge after the low-side drive turns on
      a_r5_no_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && !$past(ls_on)) |-> !sample_en);
    end
  endgenerate
endmodule

// File: rtl/ocp_hold_timer.sv
module ocp_hold_timer #(
  parameter int HOLD_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = $clog2(HOLD_TICKS);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_term;

  assign at_term = (cnt_q == TERM);
  assign done    = en & tick & at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !en)  cnt_d = '0;
    else if (tick) begin
      if (at_term) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the count only moves on a switching tick
  a_r7_count_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> $stable(cnt_q));
  // R10: a clear empties the count
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       trip,
  input  logic       hold_done,
  output ocp_state_t state,
  output logic       fault
);
  ocp_state_t st_q, st_d;
  logic       fault_q, fault_d;

  always_comb begin
    st_d    = st_q;
    fault_d = fault_q;
    if (!por_ok) begin
      st_d    = ST_OFF;
      fault_d = 1'b0;
    end else begin
      case (st_q)
        ST_OFF:  st_d = ST_RUN;
        ST_RUN:  if (trip) begin
                   st_d    = ST_HOLD;
                   fault_d = 1'b1;
                 end
        ST_HOLD: if (hold_done) begin
                   st_d    = ST_RUN;
                   fault_d = 1'b0;
                 end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
    end
  end

  assign state = st_q;
  assign fault = fault_q;

  // R6: a qualified trip while running latches the fault
  a_r6_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && por_ok && trip) |=> (fault_q && st_q == ST_HOLD));
  // R6: the fault flag and the hold state agree
  a_r6_fault_tracks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q == (st_q == ST_HOLD));
endmodule

// File: rtl/hiccup_ocp_ctrl.sv
module hiccup_ocp_ctrl
  import ocp_pkg::*;
#(
  parameter int BLANK_CYC  = 32,
  parameter int HOLD_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic sw_tick,
  input  logic ls_on,
  input  logic oc_cmp,
  output logic ss_discharge,
  output logic oc_fault,
  output logic hiccup_busy
);
  logic       rst_i_n;
  logic       sample_en;
  logic       trip;
  logic       hold_done;
  logic       in_hold;
  ocp_state_t state;
  logic       fault;

  ocp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ocp_blank_window #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ls_on     (ls_on),
    .sample_en (sample_en)
  );

  assign trip    = sample_en & oc_cmp;
  assign in_hold = (state == ST_HOLD);

  ocp_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (!por_ok),
    .en    (in_hold),
    .tick  (sw_tick),
    .done  (hold_done)
  );

  ocp_fault_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .por_ok    (por_ok),
    .trip      (trip),
    .hold_done (hold_done),
    .state     (state),
    .fault     (fault)
  );

  assign ss_discharge = (state != ST_RUN) | ~por_ok;
  assign oc_fault     = fault;
  assign hiccup_busy  = in_hold;

  // R2: losing power-on-ready clears fault and hold
  a_r2_por_clears: assert property (@(posedge clk) disable iff (!rst_i_n)
    !por_ok |=> (!oc_fault && !hiccup_busy));
  // R8: the hold is never left before its terminal tick
  a_r8_hold_not_early: assert property (@(posedge clk) disable iff (!rst_i_n)
    (hiccup_busy && por_ok && !hold_done) |=> hiccup_busy);
  // R7: the terminal tick releases the hold
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_i_n)
    hold_done |=> (!hiccup_busy && !oc_fault));
  // R6: soft-start is grounded while faulted
  a_r6_discharge_in_fault: assert property (@(posedge clk) disable iff (!rst_i_n)
    oc_fault |-> ss_discharge);
endmodule

// File: tb/sim_hiccup_ocp_ctrl.sv
module sim_hiccup_ocp_ctrl;
  localparam int BLK  = 6;
  localparam int HOLD = 4096;

  logic clk = 1'b0;
  logic rst_n, por_ok, sw_tick, ls_on, oc_cmp;
  logic ss_discharge, oc_fault, hiccup_busy;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  hiccup_ocp_ctrl #(.BLANK_CYC(BLK), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .sw_tick(sw_tick),
    .ls_on(ls_on), .oc_cmp(oc_cmp), .ss_discharge(ss_discharge),
    .oc_fault(oc_fault), .hiccup_busy(hiccup_busy)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chk3(input logic ss, input logic f, input logic b, input string req);
    chk(ss_discharge, ss, req, "ss_discharge");
    chk(oc_fault, f, req, "oc_fault");
    chk(hiccup_busy, b, req, "hiccup_busy");
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sw_tick = 1'b1; step(1);
      sw_tick = 1'b0; step(1);
    end
  endtask

  task automatic t_reset;  // R1
    rst_n = 1'b0; por_ok = 1'b0; sw_tick = 1'b0; ls_on = 1'b0; oc_cmp = 1'b0;
    step(3);
    chk3(1'b1, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    step(4);
    chk3(1'b1, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_por_up;  // R3
    por_ok = 1'b1;
    step(1);
    chk3(1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_ls_off_ignored;  // R4, plus ticks in run do nothing
    oc_cmp = 1'b1; ls_on = 1'b0;
    step(20);
    chk3(1'b0, 1'b0, 1'b0, "R4");
    oc_cmp = 1'b0;
    ticks(50);
    chk3(1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_blank_and_trip;  // R5, R6
    ls_on = 1'b1; oc_cmp = 1'b1;
    step(BLK);
    chk(oc_fault, 1'b0, "R5", "fault within blanking");
    ls_on = 1'b0;
    step(1);
    ls_on = 1'b1;
    step(BLK);
    chk(oc_fault, 1'b0, "R5", "fault after rearm");
    oc_cmp = 1'b0;
    step(3);
    chk(oc_fault, 1'b0, "R5", "no cmp");
    oc_cmp = 1'b1;
    step(1);
    chk3(1'b1, 1'b1, 1'b1, "R6");
    ls_on = 1'b0; oc_cmp = 1'b0;
  endtask

  task automatic t_hold_count;  // R7, R8
    ls_on = 1'b1; oc_cmp = 1'b1;
    step(40);
    ls_on = 1'b0; oc_cmp = 1'b0;
    ticks(HOLD - 1);
    chk3(1'b1, 1'b1, 1'b1, "R8");
    ticks(1);
    chk3(1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_retry;  // R9
    ls_on = 1'b1; oc_cmp = 1'b1;
    step(BLK);
    chk(oc_fault, 1'b0, "R9", "blanked after release");
    step(1);
    chk3(1'b1, 1'b1, 1'b1, "R9");
    ls_on = 1'b0; oc_cmp = 1'b0;
  endtask

  task automatic t_por_abort;  // R10, R2
    ticks(1000);
    chk(hiccup_busy, 1'b1, "R10", "mid hold");
    por_ok = 1'b0;
    #1;
    chk(ss_discharge, 1'b1, "R2", "ss on por low");
    step(1);
    chk3(1'b1, 1'b0, 1'b0, "R2");
    por_ok = 1'b1;
    step(1);
    chk3(1'b0, 1'b0, 1'b0, "R10");
    ls_on = 1'b1; oc_cmp = 1'b1;
    step(BLK + 1);
    chk(oc_fault, 1'b1, "R10", "retrip");
    ls_on = 1'b0; oc_cmp = 1'b0;
    ticks(HOLD - 1);
    chk(hiccup_busy, 1'b1, "R10", "full hold again");
    ticks(1);
    chk3(1'b0, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    t_reset();
    t_por_up();
    t_ls_off_ignored();
    t_blank_and_trip();
    t_hold_count();
    t_retry();
    t_por_abort();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule